// File: doc/BRIEF.md
# SPI Host Serial-Clock and Slave-Select Generator

This block holds the configuration word of an SPI host and turns it into the serial clock and the slave-select lines. A 3-bit rate field sets a power-of-two divider on the reference clock. The serial clock period is `2 << field` reference cycles, so one half period is `1 << field` cycles. Clock polarity sets the idle level of the serial clock. Clock phase decides which edge a shift engine samples on and which edge it launches on. A single-cycle tick marks every serial-clock transition, and two qualified ticks name the role of that edge.

A separate one-bit enable register gates the whole block. Polarity and phase written into the configuration word do not reach the pins at once. They are captured only when the enable goes from 0 to 1, so an enabled bus never sees a stray clock edge. The select field drives four active-low lines. It is either a one-hot pattern for direct wiring, or a binary code passed through to an external decoder. The lines can be held by software (manual select) or follow the running clock (automatic select). A shift engine reports pending work on `busy`. In manual-start mode the clock also waits for a software start trigger.

Top module: `spi_clksel_ctrl`

## Requirements
- R1: After reset the configuration word is 0x07C09 (host bit 0 = 1, rate field bits [5:3] = 1, select field bits [13:10] = 4'hF, manual-select bit 14 = 1) and the enable is 0. In this state `sclk` = 0, `ss_n` = 4'hF and all ticks are 0.
- R2: While the clock runs, consecutive `sclk` transitions are `1 << field` reference cycles apart for rate field values 1..7. A field of 0 behaves as 1.
- R3: While not running, `sclk` sits at the active polarity. When running starts (`busy` rising with the block enabled and in host mode), the divider restarts. The first transition comes exactly one half period later.
- R4: Polarity (bit 1) and phase (bit 2) written while enabled do not change `sclk` or the tick roles. They take effect when the enable register (bit 0) is next written from 0 to 1.
- R5: `bit_tick` is 1 for exactly the one cycle in which `sclk` has just changed, and is 0 otherwise. On that cycle `sample_tick` = 1 if the edge is leading (away from the polarity level) with phase 0, or trailing with phase 1. Otherwise `launch_tick` = 1.
- R6: With the decode bit (bit 9) at 0, `ss_n` drives the select field as one-hot active-low. If the field holds more than one 0, only the lowest-numbered 0 is driven low.
- R7: With the decode bit at 1, `ss_n` carries the select field unchanged as a binary code.
- R8: With manual select (bit 14) = 1, `ss_n` shows the field whenever the block is enabled in host mode. With bit 14 = 0, it shows the field only while the clock runs and is 4'hF otherwise. `ss_n` follows its cause one cycle later.
- R9: With manual start (bit 15) = 1, a high `busy` does not start the clock until a configuration write with bit 16 set. Bit 16 is not stored. The trigger is dropped when `busy` falls.
- R10: With the enable at 0 or the host bit at 0, `sclk` stays at the polarity level, `ss_n` = 4'hF and no tick fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 17 | Configuration word write data |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Enable register write data |
| busy | input | 1 | Shift engine has bits to move |
| sclk | output | 1 | Serial clock |
| ss_n | output | 4 | Slave-select lines or decoder code |
| bit_tick | output | 1 | Pulse on each serial-clock transition |
| sample_tick | output | 1 | Pulse on the edge where data is sampled |
| launch_tick | output | 1 | Pulse on the edge where data is launched |

## Verification
Clock start is timed from the input edge. After `busy` rises, or after a start-trigger write with `busy` already high, the first `sclk` transition is due exactly `1 << field` clock edges later. Each later transition is due the same number of edges after the one before. `bit_tick` and its qualified ticks are due on the same sampled cycle as the transition. `ss_n` is due one edge after the enable, `busy` or configuration change that moves it. The bench drives inputs and samples outputs on falling edges and counts rising edges from the stimulus. It compares at exactly those counts, using half periods and select patterns computed by its own functions. Polarity changes are checked twice: once right after a write while enabled, where nothing may move, and again after an enable off/on sequence.

// File: rtl/spi_clksel_pkg.sv
package spi_clksel_pkg;

    localparam int DIV_W = 3;
    localparam int SS_W  = 4;
    localparam int CNT_W = (1 << DIV_W) - 1;
    localparam int CFG_W = 17;

    localparam int B_HOST   = 0;
    localparam int B_CPOL   = 1;
    localparam int B_CPHA   = 2;
    localparam int B_DIV    = 3;
    localparam int B_DEC    = 9;
    localparam int B_SS     = 10;
    localparam int B_MSEL   = 14;
    localparam int B_MSTART = 15;
    localparam int B_TRIG   = 16;

    localparam logic [CFG_W-1:0] CFG_RST = 17'h07C09;

    typedef struct packed {
        logic             host;
        logic             cpol;
        logic             cpha;
        logic [DIV_W-1:0] div;
        logic             dec;
        logic [SS_W-1:0]  ss;
        logic             man_sel;
        logic             man_start;
    } cfg_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } mode_t;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.host      = w[B_HOST];
        c.cpol      = w[B_CPOL];
        c.cpha      = w[B_CPHA];
        c.div       = w[B_DIV +: DIV_W];
        c.dec       = w[B_DEC];
        c.ss        = w[B_SS +: SS_W];
        c.man_sel   = w[B_MSEL];
        c.man_start = w[B_MSTART];
        return c;
    endfunction

    // Last count value of one half period: (1 << div) - 1, field 0 treated as 1.
    function automatic logic [CNT_W-1:0] half_last(input logic [DIV_W-1:0] div);
        logic [CNT_W-1:0] one;
        one = 1;
        if (div == '0) begin
            return one;
        end
        return (one << div) - one;
    endfunction

    // Keep only the lowest-numbered low bit so at most one slave is selected.
    function automatic logic [SS_W-1:0] keep_lowest_low(input logic [SS_W-1:0] f);
        logic [SS_W-1:0] r;
        r = '1;
        for (int i = SS_W - 1; i >= 0; i--) begin
            if (!f[i]) begin
                r    = '1;
                r[i] = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/spi_clksel_regs.sv
module spi_clksel_regs
    import spi_clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             busy,
    output cfg_t             cfg,
    output mode_t            mode_a,
    output logic             en_q,
    output logic             started
);

    logic [CFG_W-1:0] cfg_q;
    logic             en_rise;
    logic             trig_wr;
    logic             unused_rsvd;

    assign cfg         = decode_cfg(cfg_q);
    assign en_rise     = en_we && en_wdata && !en_q;
    assign trig_wr     = cfg_we && cfg_wdata[B_TRIG] && cfg_wdata[B_MSTART];
    assign unused_rsvd = ^{cfg_q[B_DEC-1:B_DIV+DIV_W], cfg_q[B_TRIG]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RST;
        end else if (cfg_we) begin
            cfg_q         <= cfg_wdata;
            cfg_q[B_TRIG] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mode_a <= '{cpol: CFG_RST[B_CPOL], cpha: CFG_RST[B_CPHA]};
        end else begin
            if (en_we) begin
                en_q <= en_wdata;
            end
            if (en_rise) begin
                mode_a <= '{cpol: cfg.cpol, cpha: cfg.cpha};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
        end else if (!busy || !en_q) begin
            started <= 1'b0;
        end else if (trig_wr) begin
            started <= 1'b1;
        end
    end

endmodule

// File: rtl/spi_clksel_div.sv
module spi_clksel_div
    import spi_clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             bit_tick,
    output logic             sample_tick,
    output logic             launch_tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             wrap;
    logic             lead_next;
    logic             samp_next;

    assign last      = half_last(div);
    assign wrap      = run && (cnt >= last);
    assign lead_next = (~sclk) != cpol;
    assign samp_next = lead_next ^ cpha;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            sclk        <= CFG_RST[B_CPOL];
            bit_tick    <= 1'b0;
            sample_tick <= 1'b0;
            launch_tick <= 1'b0;
        end else begin
            bit_tick    <= wrap;
            sample_tick <= wrap && samp_next;
            launch_tick <= wrap && !samp_next;
            if (!run) begin
                cnt  <= '0;
                sclk <= cpol;
            end else if (wrap) begin
                cnt  <= '0;
                sclk <= ~sclk;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_clksel_sel.sv
module spi_clksel_sel
    import spi_clksel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sel_on,
    input  logic            dec,
    input  logic [SS_W-1:0] field,
    output logic [SS_W-1:0] ss_n
);

    logic [SS_W-1:0] ss_next;

    always_comb begin
        if (!sel_on) begin
            ss_next = '1;
        end else if (dec) begin
            ss_next = field;
        end else begin
            ss_next = keep_lowest_low(field);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ss_n <= '1;
        end else begin
            ss_n <= ss_next;
        end
    end

endmodule

// File: rtl/spi_clksel_ctrl.sv
module spi_clksel_ctrl
    import spi_clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             busy,
    output logic             sclk,
    output logic [SS_W-1:0]  ss_n,
    output logic             bit_tick,
    output logic             sample_tick,
    output logic             launch_tick
);

    cfg_t  cfg;
    mode_t mode_a;
    logic  en_q;
    logic  started;
    logic  run;
    logic  sel_on;

    spi_clksel_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .busy      (busy),
        .cfg       (cfg),
        .mode_a    (mode_a),
        .en_q      (en_q),
        .started   (started)
    );

    assign run    = en_q && cfg.host && busy && (!cfg.man_start || started);
    assign sel_on = en_q && cfg.host && (cfg.man_sel || run);

    spi_clksel_div u_div (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cpol        (mode_a.cpol),
        .cpha        (mode_a.cpha),
        .div         (cfg.div),
        .sclk        (sclk),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .launch_tick (launch_tick)
    );

    spi_clksel_sel u_sel (
        .clk    (clk),
        .rst    (rst),
        .sel_on (sel_on),
        .dec    (cfg.dec),
        .field  (cfg.ss),
        .ss_n   (ss_n)
    );

endmodule

// File: rtl/spi_clksel_chk.sv
module spi_clksel_chk
    import spi_clksel_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            run,
    input logic            en_q,
    input logic            cpol_a,
    input logic            cpha_a,
    input logic            cfg_dec,
    input logic            sclk,
    input logic [SS_W-1:0] ss_n,
    input logic            bit_tick,
    input logic            sample_tick,
    input logic            launch_tick
);

    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run) && $stable(cpol_a)) |-> (sclk == cpol_a));

    a_r5_tick_marks_edge: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (sclk != $past(sclk)));

    a_r5_edge_has_tick: assert property (@(posedge clk) disable iff (rst)
        ((sclk != $past(sclk)) && $past(run)) |-> bit_tick);

    a_r5_role_split: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> ($countones({sample_tick, launch_tick}) == 1));

    a_r5_role_quiet: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |-> (!sample_tick && !launch_tick));

    a_r4_mode_hold: assert property (@(posedge clk) disable iff (rst)
        en_q |=> $stable({cpol_a, cpha_a}));

    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> ((ss_n == '1) && !bit_tick));

    a_r6_single_select: assert property (@(posedge clk) disable iff (rst)
        !cfg_dec |=> ($countones(ss_n) >= SS_W - 1));

endmodule

bind spi_clksel_ctrl spi_clksel_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .en_q        (en_q),
    .cpol_a      (mode_a.cpol),
    .cpha_a      (mode_a.cpha),
    .cfg_dec     (cfg.dec),
    .sclk        (sclk),
    .ss_n        (ss_n),
    .bit_tick    (bit_tick),
    .sample_tick (sample_tick),
    .launch_tick (launch_tick)
);

// File: tb/spi_clksel_ctrl_tb.sv
module spi_clksel_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [16:0] cfg_wdata = '0;
    logic        en_we = 1'b0;
    logic        en_wdata = 1'b0;
    logic        busy = 1'b0;
    logic        sclk;
    logic [3:0]  ss_n;
    logic        bit_tick;
    logic        sample_tick;
    logic        launch_tick;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_clksel_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .en_we       (en_we),
        .en_wdata    (en_wdata),
        .busy        (busy),
        .sclk        (sclk),
        .ss_n        (ss_n),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .launch_tick (launch_tick)
    );

    function automatic logic [16:0] mk(input bit host, input bit cpol, input bit cpha,
                                       input int div, input bit dec, input logic [3:0] ss,
                                       input bit msel, input bit mstart, input bit trig);
        logic [16:0] w;
        w = '0;
        w[0] = host; w[1] = cpol; w[2] = cpha;
        w[5:3] = div[2:0];
        w[9] = dec;
        w[13:10] = ss;
        w[14] = msel; w[15] = mstart; w[16] = trig;
        return w;
    endfunction

    function automatic int exp_half(input int div);
        return (div == 0) ? 2 : (1 << div);
    endfunction

    function automatic logic [3:0] exp_sel(input logic [3:0] f);
        for (int i = 0; i < 4; i++) begin
            if (!f[i]) return ~(4'b0001 << i);
        end
        return 4'hF;
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [16:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_en(input bit v);
        @(negedge clk);
        en_we = 1'b1;
        en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count ticks over n cycles while nothing should run
    task automatic quiet_for(input int n, output int ticks);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bit_tick || sample_tick || launch_tick) ticks++;
        end
    endtask

    // Clock was started one negedge before the call; time each transition
    task automatic measure(input int h, input bit cpol, input bit cpha, input int ntog);
        logic last;
        int   cnt;
        int   early;
        bit   lead;
        last = cpol;
        for (int t = 0; t < ntog; t++) begin
            cnt = 0;
            early = 0;
            do begin
                @(negedge clk);
                cnt++;
                if (sclk == last && bit_tick) early++;
            end while (sclk == last && cnt < 400);
            check_eq((t == 0) ? "R3" : "R2", "half period cycles", cnt, h);
            check_eq("R5", "ticks between edges", early, 0);
            check_eq("R5", "bit_tick at edge", int'(bit_tick), 1);
            lead = (sclk != cpol);
            check_eq("R5", "sample_tick role", int'(sample_tick), int'(lead ^ cpha));
            check_eq("R5", "launch_tick role", int'(launch_tick), int'(!(lead ^ cpha)));
            last = sclk;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int ticks;
        int div;
        bit cp, ch;
        logic [3:0] f;
        void'($urandom(32'd4711));

        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);

        // R1 reset state
        check_eq("R1", "sclk after reset", int'(sclk), 0);
        check_eq("R1", "ss_n after reset", int'(ss_n), 15);
        quiet_for(5, ticks);
        check_eq("R1", "ticks after reset", ticks, 0);
        // R10 enable low with busy high
        busy = 1'b1;
        quiet_for(10, ticks);
        check_eq("R10", "ticks while disabled", ticks, 0);
        check_eq("R10", "sclk while disabled", int'(sclk), 0);
        check_eq("R10", "ss_n while disabled", int'(ss_n), 15);
        busy = 1'b0;

        // R1 defaults: divide by 4, no slave selected
        write_en(1'b1);
        wait_cyc(2);
        check_eq("R1", "ss_n default field", int'(ss_n), 15);
        @(negedge clk); busy = 1'b1;
        measure(2, 1'b0, 1'b0, 4);
        @(negedge clk); busy = 1'b0;
        wait_cyc(2);
        check_eq("R3", "sclk back to idle", int'(sclk), 0);

        // R2/R3/R5 directed extremes then random modes
        for (int it = 0; it < 12; it++) begin
            if (it == 0) begin div = 0; cp = 1; ch = 0; end
            else if (it == 1) begin div = 7; cp = 0; ch = 1; end
            else begin div = $urandom % 8; cp = $urandom % 2; ch = $urandom % 2; end
            write_en(1'b0);
            write_cfg(mk(1, cp, ch, div, 0, 4'hE, 1, 0, 0));
            write_en(1'b1);
            wait_cyc(2);
            check_eq("R3", "idle level before start", int'(sclk), int'(cp));
            @(negedge clk); busy = 1'b1;
            measure(exp_half(div), cp, ch, 4);
            @(negedge clk); busy = 1'b0;
            wait_cyc(2);
            check_eq("R3", "idle level after stop", int'(sclk), int'(cp));
        end

        // R4 mode change while enabled is deferred
        write_en(1'b0);
        write_cfg(mk(1, 0, 0, 1, 0, 4'hE, 1, 0, 0));
        write_en(1'b1);
        write_cfg(mk(1, 1, 1, 1, 0, 4'hE, 1, 0, 0));
        wait_cyc(3);
        check_eq("R4", "sclk held at old polarity", int'(sclk), 0);
        @(negedge clk); busy = 1'b1;
        measure(2, 1'b0, 1'b0, 2);
        @(negedge clk); busy = 1'b0;
        write_en(1'b0);
        write_en(1'b1);
        wait_cyc(2);
        check_eq("R4", "sclk at new polarity after re-enable", int'(sclk), 1);
        @(negedge clk); busy = 1'b1;
        measure(2, 1'b1, 1'b1, 2);
        @(negedge clk); busy = 1'b0;

        // R6 one-hot mode with guard
        write_cfg(mk(1, 1, 1, 1, 0, 4'b0110, 1, 0, 0));
        wait_cyc(2);
        check_eq("R6", "two lows keep lowest", int'(ss_n), int'(4'b1110));
        for (int k = 0; k < 6; k++) begin
            f = 4'($urandom);
            write_cfg(mk(1, 1, 1, 1, 0, f, 1, 0, 0));
            wait_cyc(1);
            check_eq("R6", "one-hot select", int'(ss_n), int'(exp_sel(f)));
        end

        // R7 decoded mode passes code
        write_cfg(mk(1, 1, 1, 1, 1, 4'b0110, 1, 0, 0));
        wait_cyc(1);
        check_eq("R7", "decoded code", int'(ss_n), int'(4'b0110));
        write_cfg(mk(1, 1, 1, 1, 1, 4'b0011, 1, 0, 0));
        wait_cyc(1);
        check_eq("R7", "decoded code 3", int'(ss_n), int'(4'b0011));

        // R8 automatic select follows the running clock
        write_cfg(mk(1, 1, 1, 2, 0, 4'b1011, 0, 0, 0));
        wait_cyc(2);
        check_eq("R8", "auto select idle", int'(ss_n), 15);
        @(negedge clk); busy = 1'b1;
        @(negedge clk);
        check_eq("R8", "auto select running", int'(ss_n), int'(4'b1011));
        @(negedge clk); busy = 1'b0;
        @(negedge clk);
        check_eq("R8", "auto select released", int'(ss_n), 15);
        write_cfg(mk(1, 1, 1, 2, 0, 4'b1011, 1, 0, 0));
        wait_cyc(1);
        check_eq("R8", "manual select held idle", int'(ss_n), int'(4'b1011));

        // R9 manual start
        write_cfg(mk(1, 0, 0, 2, 0, 4'b1110, 1, 1, 0));
        write_en(1'b0);
        write_en(1'b1);
        @(negedge clk); busy = 1'b1;
        quiet_for(20, ticks);
        check_eq("R9", "no clock before trigger", ticks, 0);
        check_eq("R9", "sclk idle before trigger", int'(sclk), 0);
        write_cfg(mk(1, 0, 0, 2, 0, 4'b1110, 1, 1, 1));
        measure(4, 1'b0, 1'b0, 3);
        @(negedge clk); busy = 1'b0;
        @(negedge clk); busy = 1'b1;
        quiet_for(20, ticks);
        check_eq("R9", "trigger dropped when busy fell", ticks, 0);
        busy = 1'b0;

        // R10 host bit cleared
        write_cfg(mk(0, 0, 0, 1, 0, 4'b1110, 1, 0, 0));
        @(negedge clk); busy = 1'b1;
        quiet_for(12, ticks);
        check_eq("R10", "ticks with host bit clear", ticks, 0);
        check_eq("R10", "ss_n with host bit clear", int'(ss_n), 15);
        check_eq("R10", "sclk with host bit clear", int'(sclk), 0);
        busy = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule